// File: doc/BRIEF.md
# Radix-2 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full `2*WIDTH`-bit signed product. A pulse on `start` captures both operands. The block then makes exactly `WIDTH` passes over the multiplier bits. On each pass it examines the lowest multiplier bit together with the bit that was shifted out on the previous pass. From that pair it chooses one of three actions: add the multiplicand to the running accumulator, subtract it, or leave the accumulator alone. Every pass then ends with one arithmetic right shift of the joined accumulator, multiplier and trailing-bit register. Because the choice depends on this bit pair, long runs of equal multiplier bits cost only shifts.

The accumulator and the adder/subtractor are one bit wider than the operands. This keeps the most negative multiplicand exact, with no overflow in any partial sum. `done` pulses for one cycle when the last pass has completed. `product` then keeps its value until the next accepted start. A start is accepted in the idle state and in the cycle where `done` is high. A start that arrives while passes are still running is ignored.

Top module: `booth_mul_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `done` is 0 and `product` is 0.
- R2: A start that is accepted on clock edge k makes `done` read 1 in the cycle after edge k+WIDTH. `done` reads 0 in every cycle between those two points.
- R3: When the pair (multiplier LSB, trailing bit) is 1,0, the multiplicand is subtracted from the accumulator before the shift. Worked case: 3 times -5 with WIDTH=8 gives 16'hFFF1.
- R4: When the pair is 0,1, the multiplicand is added to the accumulator before the shift. Example: multiplier 2 subtracts on the second pass and adds on the third pass, and the result equals twice the multiplicand.
- R5: When the pair is 0,0 or 1,1, no arithmetic is done and only the shift happens. A zero multiplier gives 0. A multiplier of all ones gives the negated multiplicand.
- R6: `product` equals the signed product of the captured operands for every combination of operand signs.
- R7: The most negative operand value, used as multiplicand, as multiplier or as both, gives the exact signed product.
- R8: `done` is high for exactly one cycle. `product` then stays unchanged until the next accepted start.
- R9: A start that arrives while passes are running is ignored. The operands it presents have no effect on the result or on the timing.
- R10: A start that arrives in the cycle where `done` is high is accepted. It begins a new multiplication with the full R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to capture operands and begin |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product |

## Verification
Two events can fall in the same cycle: the completion pulse of one multiplication and the acceptance of the next start. The bench provokes this by raising `start` with new operands in the very cycle where it sees `done` high. It then judges the restart by two things: the pass count to the next `done` must be exactly WIDTH, and the new product must be correct. A start raised in the middle of a run, with different operands, must change neither the result nor the latency.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } booth_act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } booth_st_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic       cur_bit,
  input  logic       prev_bit,
  output booth_act_e act
);

  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   act = ACT_SUB;
      2'b01:   act = ACT_ADD;
      default: act = ACT_HOLD;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW = WIDTH + 1
) (
  input  logic [AW-1:0]    acc_in,
  input  logic [WIDTH-1:0] mcand,
  input  booth_act_e       act,
  output logic [AW-1:0]    acc_out
);

  logic [AW-1:0] m_ext;
  logic [AW-1:0] operand;
  logic          cin;

  assign m_ext = {mcand[WIDTH-1], mcand};

  always_comb begin
    operand = '0;
    cin     = 1'b0;
    case (act)
      ACT_ADD: begin
        operand = m_ext;
        cin     = 1'b0;
      end
      ACT_SUB: begin
        operand = ~m_ext;
        cin     = 1'b1;
      end
      default: begin
        operand = '0;
        cin     = 1'b0;
      end
    endcase
  end

  assign acc_out = acc_in + operand + AW'(cin);

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic busy,
  output logic done
);

  booth_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_pass;

  assign last_pass = (cnt_q == CW'(WIDTH - 1));
  assign busy      = (st_q == ST_RUN);
  assign step_en   = busy;
  assign load_en   = start && !busy;
  assign done      = (st_q == ST_FIN);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          st_d  = ST_IDLE;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + CW'(1);
        if (last_pass) st_d = ST_FIN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDTH-1:0]     mcand,
  input  logic [WIDTH-1:0]     mplier,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);

  localparam int AW = WIDTH + 1;

  logic             load_en, step_en, busy;
  logic [AW-1:0]    acc_q, acc_d;
  logic [WIDTH-1:0] q_q, q_d;
  logic             tail_q, tail_d;
  logic [WIDTH-1:0] m_q, m_d;
  logic [AW-1:0]    sum;
  booth_act_e       act;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load_en (load_en),
    .step_en (step_en),
    .busy    (busy),
    .done    (done)
  );

  booth_recode u_recode (
    .cur_bit  (q_q[0]),
    .prev_bit (tail_q),
    .act      (act)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc_in  (acc_q),
    .mcand   (m_q),
    .act     (act),
    .acc_out (sum)
  );

  always_comb begin
    acc_d  = acc_q;
    q_d    = q_q;
    tail_d = tail_q;
    m_d    = m_q;
    if (load_en) begin
      acc_d  = '0;
      q_d    = mplier;
      tail_d = 1'b0;
      m_d    = mcand;
    end else if (step_en) begin
      acc_d  = {sum[AW-1], sum[AW-1:1]};
      q_d    = {sum[0], q_q[WIDTH-1:1]};
      tail_d = q_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      q_q    <= '0;
      tail_q <= 1'b0;
      m_q    <= '0;
    end else if (load_en || step_en) begin
      acc_q  <= acc_d;
      q_q    <= q_d;
      tail_q <= tail_d;
      m_q    <= m_d;
    end
  end

  assign product = {acc_q[WIDTH-1:0], q_q};

endmodule

module booth_mul_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  int win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              win_cnt <= 0;
    else if (start && !busy) win_cnt <= 0;
    else if (busy)           win_cnt <= win_cnt + 1;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && win_cnt < WIDTH - 1) |=> busy);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (win_cnt == WIDTH));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!done && product == '0));

endmodule

bind booth_mul_seq booth_mul_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/booth_mul_seq_test.sv
module booth_mul_seq_test;

  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  booth_mul_seq #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand(mcand), .mplier(mplier),
    .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  // Called at a negedge with start already high; drops start and waits for done.
  task automatic finish_run(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int lat;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 4*W) begin
      @(negedge clk);
      lat++;
    end
    check(lat == W, "R2 latency", lat, W);
    check(product == ref_mul(a, b), req, product, ref_mul(a, b));
  endtask

  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    finish_run(a, b, req);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(product == '0, "R1 product in reset", product, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done idle", done, 0);
    check(product == '0, "R1 product idle", product, 0);
  endtask

  task automatic t_subtract();
    run_mul(8'd3, 8'hFB, "R3 3*-5");
    check(product == 16'hFFF1, "R3 literal FFF1", product, 16'hFFF1);
  endtask

  task automatic t_add();
    run_mul(8'd37, 8'd2, "R4 add after subtract");
    run_mul(8'hC3, 8'd2, "R4 negative mcand");
    run_mul(8'd9, 8'd1, "R4 mplier 1");
  endtask

  task automatic t_shift_only();
    run_mul(8'd77, 8'd0, "R5 zero mplier");
    run_mul(8'd77, 8'hFF, "R5 all ones mplier");
    run_mul(8'hA5, 8'h0F, "R5 low run of ones");
    run_mul(8'h5A, 8'hF0, "R5 high run of ones");
  endtask

  task automatic t_signs();
    logic [W-1:0] vals [12] = '{8'd0, 8'd1, 8'd2, 8'd5, 8'd63, 8'd127,
                                8'hFF, 8'hFE, 8'hF6, 8'hAA, 8'h81, 8'h55};
    foreach (vals[i]) begin
      foreach (vals[j]) run_mul(vals[i], vals[j], "R6 sign sweep");
    end
  endtask

  task automatic t_min_neg();
    run_mul(8'h80, 8'h80, "R7 min*min");
    run_mul(8'h80, 8'h7F, "R7 min*max");
    run_mul(8'h7F, 8'h80, "R7 max*min");
    run_mul(8'h80, 8'hFF, "R7 min*-1");
    run_mul(8'h80, 8'd1, "R7 min*1");
  endtask

  task automatic t_hold();
    logic [2*W-1:0] held;
    run_mul(8'd23, 8'hE9, "R8 setup");
    held = product;
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    mcand = 8'h11; mplier = 8'h22;
    repeat (4) @(negedge clk);
    check(product == held, "R8 product held", product, held);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    start = 1'b1; mcand = 8'd19; mplier = 8'hF3;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; mcand = 8'h7F; mplier = 8'h7F;
    @(negedge clk);
    start = 1'b0;
    begin
      int lat;
      lat = 4;
      while (!done && lat < 4*W) begin
        @(negedge clk);
        lat++;
      end
      check(lat == W, "R9 latency unchanged", lat, W);
    end
    check(product == ref_mul(8'd19, 8'hF3), "R9 mid-run start ignored", product, ref_mul(8'd19, 8'hF3));
  endtask

  task automatic t_restart();
    run_mul(8'd45, 8'd6, "R10 first");
    start = 1'b1; mcand = 8'hD7; mplier = 8'd11;
    finish_run(8'hD7, 8'd11, "R10 restart on done");
  endtask

  initial begin
    t_reset();
    t_subtract();
    t_add();
    t_shift_only();
    t_signs();
    t_min_neg();
    t_hold();
    t_busy_ignore();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule